// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the byte a flash-style memory returns on a read strobe while its internal program or erase engine is running or suspended. In a status read it reports progress as a byte. Bit 7 is the data-polling bit. Bit 6 is a toggle bit that flips on every status read. Bit 5 reports an exceeded pulse-count limit. Bit 3 shows whether the sector-erase collection window has closed. When no status is due, the byte comes from the external array read path.

The engine drives the operation kind, busy, suspended and timeout signals. It also pulses `start_i` when an operation begins, and it supplies the last programmed byte and the state of the collection window. The read path supplies the array byte and a flag that the read address lies in the sector being erased. Each read strobe captures one byte into the output register. That byte holds until the next strobe.

Host software detects completion in one of two ways. It can read bit 7 until it matches the written value, or it can compare bit 6 across two back-to-back reads until it stops changing.

Top module: `opstat_gen`

## Requirements
- R1: While busy with a program (`op_kind_i`=0), a read returns bit 7 as the inverse of bit 7 of `wdata_i`. This also holds when the erase is suspended.
- R2: While busy with an erase (`op_kind_i`=1) that is not suspended, a read returns bit 7 as 0.
- R3: Every read that returns a status byte carries the toggle value in bit 6 and then inverts that value. A `start_i` pulse forces the value to 0, so the first status read after a start shows 0.
- R4: In a status read during a busy program or erase, bit 5 equals `tmo_i`.
- R5: When not busy and not suspended, a read returns `array_i` unchanged. This gives the true data once an operation is complete.
- R6: In a status read during an unsuspended erase, bit 3 is 0 while `win_open_i` is 1 and 1 while it is 0.
- R7: While suspended and not busy, a read with `in_erase_sec_i`=0 returns `array_i`. A read with `in_erase_sec_i`=1 returns 1 in bit 7, the toggle value in bit 6 and 0 in every other bit.
- R8: A program started during a suspend (`busy_i`=1, `op_kind_i`=0, `susp_i`=1) reports the same pattern as R1, R3 and R4.
- R9: In every status byte, each bit that R1 to R7 do not define reads 0.
- R10: A read that returns array data leaves the toggle value unchanged.
- R11: `dout_o` is 0 after reset. It takes its new value on the clock edge that samples `rd_i`=1, and it holds while `rd_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_kind_i | input | 1 | Operation kind: 0 program, 1 erase |
| busy_i | input | 1 | Engine is running an operation |
| susp_i | input | 1 | Erase is suspended |
| tmo_i | input | 1 | Pulse-count limit exceeded |
| start_i | input | 1 | One-cycle pulse at operation start |
| wdata_i | input | DW | Byte last written by a program command |
| win_open_i | input | 1 | Sector-erase collection window still open |
| in_erase_sec_i | input | 1 | Read address lies in the sector being erased |
| array_i | input | DW | Array data from the external read path |
| rd_i | input | 1 | Read strobe, one cycle per read |
| dout_o | output | DW | Registered read byte |

## Verification
On every read, the assertions check the polling bit in program and erase modes, the timer bit and the timeout bit during busy reads, and the array pass-through when idle. They also check that the output holds between strobes.

The toggle sequence spans several reads, so only the bench's scenarios show it. Those scenarios cover the clear at start and the flip on each status read. They also cover the freeze on array reads that interleave during a suspend, and the restart when a program is launched inside a suspend.

// File: rtl/opstat_pkg.sv
package opstat_pkg;
  typedef enum logic [1:0] {
    SEL_ARRAY = 2'd0,
    SEL_PROG  = 2'd1,
    SEL_ERASE = 2'd2,
    SEL_SUSP  = 2'd3
  } sel_e;

  localparam int POLL_BIT = 7;
  localparam int TOG_BIT  = 6;
  localparam int TLIM_BIT = 5;
  localparam int TMR_BIT  = 3;
endpackage

// File: rtl/opstat_mode.sv
module opstat_mode
  import opstat_pkg::*;
(
  input  logic busy_i,
  input  logic susp_i,
  input  logic op_kind_i,
  input  logic in_erase_sec_i,
  output sel_e sel_o
);
  // program wins over suspend: covers program issued inside a suspend
  always_comb begin
    if (busy_i && !op_kind_i)                sel_o = SEL_PROG;
    else if (busy_i && op_kind_i && !susp_i) sel_o = SEL_ERASE;
    else if (susp_i && in_erase_sec_i)       sel_o = SEL_SUSP;
    else                                     sel_o = SEL_ARRAY;
  end
endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic adv_i,
  output logic tog_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tog_o <= 1'b0;
    else if (clr_i)  tog_o <= 1'b0;
    else if (adv_i)  tog_o <= ~tog_o;
  end
endmodule

// File: rtl/opstat_enc.sv
module opstat_enc
  import opstat_pkg::*;
#(
  parameter int DW = 8
) (
  input  sel_e          sel_i,
  input  logic          tog_i,
  input  logic          tmo_i,
  input  logic          wd_msb_i,
  input  logic          win_open_i,
  input  logic [DW-1:0] array_i,
  output logic [DW-1:0] stat_o
);
  always_comb begin
    stat_o = '0;
    unique case (sel_i)
      SEL_PROG: begin
        stat_o[POLL_BIT] = ~wd_msb_i;
        stat_o[TOG_BIT]  = tog_i;
        stat_o[TLIM_BIT] = tmo_i;
      end
      SEL_ERASE: begin
        stat_o[TOG_BIT]  = tog_i;
        stat_o[TLIM_BIT] = tmo_i;
        stat_o[TMR_BIT]  = ~win_open_i;
      end
      SEL_SUSP: begin
        stat_o[POLL_BIT] = 1'b1;
        stat_o[TOG_BIT]  = tog_i;
      end
      default: stat_o = array_i;
    endcase
  end
endmodule

// File: rtl/opstat_gen.sv
module opstat_gen
  import opstat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_kind_i,
  input  logic          busy_i,
  input  logic          susp_i,
  input  logic          tmo_i,
  input  logic          start_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          win_open_i,
  input  logic          in_erase_sec_i,
  input  logic [DW-1:0] array_i,
  input  logic          rd_i,
  output logic [DW-1:0] dout_o
);
  localparam int MSB = DW - 1;

  sel_e          sel;
  logic          tog;
  logic          stat_rd;
  logic [DW-1:0] stat;

  opstat_mode u_mode (
    .busy_i         (busy_i),
    .susp_i         (susp_i),
    .op_kind_i      (op_kind_i),
    .in_erase_sec_i (in_erase_sec_i),
    .sel_o          (sel)
  );

  assign stat_rd = rd_i && (sel != SEL_ARRAY);

  opstat_toggle u_tog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .adv_i  (stat_rd),
    .tog_o  (tog)
  );

  opstat_enc #(.DW(DW)) u_enc (
    .sel_i      (sel),
    .tog_i      (tog),
    .tmo_i      (tmo_i),
    .wd_msb_i   (wdata_i[MSB]),
    .win_open_i (win_open_i),
    .array_i    (array_i),
    .stat_o     (stat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_o <= '0;
    else if (rd_i) dout_o <= stat;
  end
endmodule

// File: rtl/opstat_gen_chk.sv
module opstat_gen_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          op_kind_i,
  input logic          busy_i,
  input logic          susp_i,
  input logic          tmo_i,
  input logic [DW-1:0] wdata_i,
  input logic          win_open_i,
  input logic          in_erase_sec_i,
  input logic [DW-1:0] array_i,
  input logic          rd_i,
  input logic [DW-1:0] dout_o
);
  AST_PROG_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_i && !op_kind_i |=> dout_o[7] == !$past(wdata_i[7])); // R1

  AST_ERASE_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_i && op_kind_i && !susp_i |=> dout_o[7] == 1'b0); // R2

  AST_TIME_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_i && (!op_kind_i || !susp_i) |=> dout_o[5] == $past(tmo_i)); // R4

  AST_ARRAY_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !busy_i && !susp_i |=> dout_o == $past(array_i)); // R5

  AST_WIN_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && busy_i && op_kind_i && !susp_i |=> dout_o[3] == !$past(win_open_i)); // R6

  AST_SUSP_OTHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !busy_i && susp_i && !in_erase_sec_i |=> dout_o == $past(array_i)); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(dout_o)); // R11
endmodule

bind opstat_gen opstat_gen_chk #(.DW(DW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .op_kind_i      (op_kind_i),
  .busy_i         (busy_i),
  .susp_i         (susp_i),
  .tmo_i          (tmo_i),
  .wdata_i        (wdata_i),
  .win_open_i     (win_open_i),
  .in_erase_sec_i (in_erase_sec_i),
  .array_i        (array_i),
  .rd_i           (rd_i),
  .dout_o         (dout_o)
);

// File: tb/opstat_gen_test.sv
module opstat_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_kind = 1'b0, busy = 1'b0, susp = 1'b0, tmo = 1'b0, start = 1'b0;
  logic [7:0] wdata = '0, arr = '0;
  logic       win_open = 1'b0, in_sec = 1'b0, rd = 1'b0;
  logic [7:0] dout;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] last_exp = '0;

  always #5 clk = ~clk;

  opstat_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .op_kind_i(op_kind), .busy_i(busy),
    .susp_i(susp), .tmo_i(tmo), .start_i(start), .wdata_i(wdata),
    .win_open_i(win_open), .in_erase_sec_i(in_sec), .array_i(arr),
    .rd_i(rd), .dout_o(dout)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    last_exp = exp;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // monitor: output is valid at the negedge after the edge that saw rd
  initial begin
    forever begin
      @(posedge clk);
      if (rd) begin
        @(negedge clk);
        check(dout, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(dout, 8'h00, "R11 reset value");
    rst_n = 1'b1;

    // idle: array pass-through
    arr = 8'h5A;
    do_read(8'h5A, "R5 idle array");

    // program with wdata bit7=1
    op_kind = 1'b0; busy = 1'b1; wdata = 8'h80;
    pulse_start();
    do_read(8'h00, "R1 R3 R9 prog first read");
    do_read(8'h40, "R3 prog toggle");
    do_read(8'h00, "R3 prog toggle back");
    wdata = 8'h3C;
    do_read(8'hC0, "R1 prog inverted msb");
    tmo = 1'b1;
    do_read(8'hA0, "R4 prog timeout");
    tmo = 1'b0;
    busy = 1'b0; arr = 8'h3C;
    do_read(8'h3C, "R5 prog complete true data");
    do_read(8'h3C, "R5 R3 no toggle when done");

    // erase
    op_kind = 1'b1; busy = 1'b1; win_open = 1'b1; arr = 8'hFF;
    pulse_start();
    do_read(8'h00, "R2 R6 erase window open");
    win_open = 1'b0;
    do_read(8'h48, "R6 R3 erase window closed");
    tmo = 1'b1;
    do_read(8'h28, "R4 erase timeout");
    tmo = 1'b0;
    busy = 1'b0;
    do_read(8'hFF, "R5 erase complete");

    // suspend
    busy = 1'b1;
    pulse_start();
    do_read(8'h08, "R2 erase before suspend");
    busy = 1'b0; susp = 1'b1; in_sec = 1'b0; arr = 8'h12;
    do_read(8'h12, "R7 suspend other sector");
    in_sec = 1'b1;
    do_read(8'hC0, "R7 R10 suspended sector toggle kept");
    in_sec = 1'b0;
    do_read(8'h12, "R10 array read in suspend");
    in_sec = 1'b1;
    do_read(8'h80, "R7 R10 suspended sector next");

    // program inside suspend
    op_kind = 1'b0; busy = 1'b1; wdata = 8'h01;
    pulse_start();
    do_read(8'h80, "R8 suspend program first");
    do_read(8'hC0, "R8 suspend program toggle");
    tmo = 1'b1;
    do_read(8'hA0, "R8 suspend program timeout");
    tmo = 1'b0;

    // hold between strobes
    arr = 8'h99; busy = 1'b0; susp = 1'b0; in_sec = 1'b0;
    repeat (4) @(negedge clk);
    check(dout, last_exp, "R11 hold without strobe");
    do_read(8'h99, "R11 update on strobe");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule